// File: doc/BRIEF.md
# Crypto Access-Error Status Unit

This block holds the status and error flags for the host side of a block-cipher accelerator. It follows every 128-bit block through three phases. In the input phase it counts four 32-bit writes to the data-input register. In the compute phase it runs a fixed-latency countdown. In the output phase it counts four 32-bit reads from the data-output register. When the host touches a data register at the wrong time, the block raises a sticky error flag and leaves the sequencing exactly as it was.

Detection depends on the engine's mode and chaining phase. Key derivation and some authenticated-mode phases mask it, and those same modes skip the output phase. The block also provides a compute-complete flag and a busy indication that applies only to GCM payload encryption. All flags appear in a 32-bit read-only status word, and a level-sensitive error interrupt is driven from them. The cipher datapath and the control-register decode sit outside the block; they appear here only as plain inputs.

Top module: `crypto_status_unit`

## Requirements
- R1: After synchronous reset the status word reads 0x00000000 and `err_irq` is 0.
- R2: Status word layout: bit 0 compute-complete, bit 1 read error, bit 2 write error, bit 3 busy. Bits 31:4 always read 0.
- R3: The fourth accepted write in the input phase starts computation. The compute-complete flag becomes visible CALC_CYCLES clock edges after the edge that took that write. Output then needs exactly four reads before the unit returns to the input phase.
- R4: A write strobe during the compute or output phase sets the write-error flag, unless detection is masked.
- R5: A read strobe during the input or compute phase sets the read-error flag, unless detection is masked.
- R6: Both error flags are sticky and are cleared only by `err_clr`. An error event in the same cycle as `err_clr` leaves the flag set. `ccf_clr` has no effect on the error flags.
- R7: The compute-complete flag is cleared only by `ccf_clr`. If completion and `ccf_clr` fall in the same cycle, the flag stays set. `err_clr` does not touch it.
- R8: An illegal access is not counted and does not shift the timing of the compute-complete flag.
- R9: With `key_deriv`=1 no error flag is set, and after computation the unit returns straight to the input phase.
- R10: With `aead_en`=1, `aead_phase`=0 (init) masks both error kinds and `aead_phase`=1 (header) masks only read errors. Both phases skip the output phase. Phase 2 is payload and phase 3 is final.
- R11: Busy reads 1 only when `aead_en`=1, `aead_is_gcm`=1, `aead_phase`=2, `dir_encrypt`=1, `key_deriv`=0, and the unit is not sitting at a block boundary in the input phase (no words taken yet). Otherwise it reads 0. It follows the state and mode with one register stage.
- R12: `err_irq` is a registered level equal to (read error OR write error) AND `err_ie`. It follows a change of `err_ie` one edge later.
- R13: While `eng_en`=0 the unit returns to the input phase with no words counted, and no error flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| eng_en | input | 1 | Engine enable |
| host_wr_din | input | 1 | Host write strobe to the data-input register |
| host_rd_dout | input | 1 | Host read strobe from the data-output register |
| key_deriv | input | 1 | Key-derivation mode selected |
| aead_en | input | 1 | Authenticated chaining (GCM or CCM) selected |
| aead_is_gcm | input | 1 | 1 = GCM, 0 = CCM |
| aead_phase | input | 2 | 0 init, 1 header, 2 payload, 3 final |
| dir_encrypt | input | 1 | 1 = encryption |
| err_clr | input | 1 | Clear both error flags |
| ccf_clr | input | 1 | Clear the compute-complete flag |
| err_ie | input | 1 | Error interrupt enable |
| status_word | output | 32 | Read-only status word |
| err_irq | output | 1 | Level error interrupt |

## Verification
Two pairs of functions can land on the same edge: an error event with `err_clr`, and the end of computation with `ccf_clr`. The first pair is provoked by a read strobe in the input phase with `err_clr` held high on the same edge. The second is provoked by raising `ccf_clr` exactly CALC_CYCLES edges after the fourth write. In both cases the flag must read 1 afterwards, and a lone clear on the next edge must bring it to 0. Masking and the ignored-access rule are judged from the ports: a later access shows which phase the unit actually sits in.

// File: rtl/cst_pkg.sv
package cst_pkg;
  typedef enum logic [1:0] {
    PH_IN   = 2'd0,
    PH_CALC = 2'd1,
    PH_OUT  = 2'd2
  } phase_t;

  typedef enum logic [1:0] {
    AP_INIT    = 2'd0,
    AP_HEADER  = 2'd1,
    AP_PAYLOAD = 2'd2,
    AP_FINAL   = 2'd3
  } aead_phase_t;

  // flag bank slots
  localparam int FL_CCF = 0;
  localparam int FL_RD  = 1;
  localparam int FL_WR  = 2;
  localparam int FL_N   = 3;

  // status word bit positions
  localparam int ST_BUSY = 3;
  localparam int ST_W    = 32;
endpackage

// File: rtl/cst_phase_tracker.sv
module cst_phase_tracker
  import cst_pkg::*;
#(
  parameter int WORDS       = 4,
  parameter int CALC_CYCLES = 10
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   eng_en,
  input  logic   wr_stb,
  input  logic   rd_stb,
  input  logic   skip_out,
  output phase_t phase_q,
  output logic   calc_done,
  output logic   busy_d
);
  localparam int CNT_W = $clog2(WORDS + 1);
  localparam int TMR_W = $clog2(CALC_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST_WORD = CNT_W'(WORDS - 1);
  localparam logic [TMR_W-1:0] TMR_LOAD  = TMR_W'(CALC_CYCLES - 1);

  phase_t           phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [TMR_W-1:0] tmr_q, tmr_d;

  always_comb begin
    phase_d   = phase_q;
    cnt_d     = cnt_q;
    tmr_d     = tmr_q;
    calc_done = 1'b0;
    if (!eng_en) begin
      phase_d = PH_IN;
      cnt_d   = '0;
      tmr_d   = '0;
    end else begin
      case (phase_q)
        PH_IN: begin
          if (wr_stb) begin
            if (cnt_q == LAST_WORD) begin
              phase_d = PH_CALC;
              cnt_d   = '0;
              tmr_d   = TMR_LOAD;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
        end
        PH_CALC: begin
          if (tmr_q == '0) begin
            calc_done = 1'b1;
            phase_d   = skip_out ? PH_IN : PH_OUT;
          end else begin
            tmr_d = tmr_q - 1'b1;
          end
        end
        PH_OUT: begin
          if (rd_stb) begin
            if (cnt_q == LAST_WORD) begin
              phase_d = PH_IN;
              cnt_d   = '0;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
        end
        default: begin
          phase_d = PH_IN;
          cnt_d   = '0;
        end
      endcase
    end
    busy_d = (phase_d != PH_IN) || (cnt_d != '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IN;
      cnt_q   <= '0;
      tmr_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      tmr_q   <= tmr_d;
    end
  end
endmodule

// File: rtl/cst_access_guard.sv
module cst_access_guard
  import cst_pkg::*;
(
  input  logic       eng_en,
  input  phase_t     phase,
  input  logic       wr_stb,
  input  logic       rd_stb,
  input  logic       key_deriv,
  input  logic       aead_en,
  input  logic       aead_is_gcm,
  input  logic [1:0] aead_phase,
  input  logic       dir_encrypt,
  output logic       wr_evt,
  output logic       rd_evt,
  output logic       skip_out,
  output logic       busy_gate
);
  aead_phase_t ap;
  logic in_init, in_header, wr_mask, rd_mask;

  always_comb begin
    ap        = aead_phase_t'(aead_phase);
    in_init   = aead_en && (ap == AP_INIT);
    in_header = aead_en && (ap == AP_HEADER);
    wr_mask   = key_deriv || in_init;
    rd_mask   = key_deriv || in_init || in_header;
    wr_evt    = eng_en && wr_stb && !wr_mask &&
                ((phase == PH_CALC) || (phase == PH_OUT));
    rd_evt    = eng_en && rd_stb && !rd_mask &&
                ((phase == PH_CALC) || (phase == PH_IN));
    skip_out  = key_deriv || in_init || in_header;
    busy_gate = aead_en && aead_is_gcm && (ap == AP_PAYLOAD) &&
                dir_encrypt && !key_deriv;
  end
endmodule

// File: rtl/cst_flag_bank.sv
module cst_flag_bank #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_q,
  output logic [N-1:0] flag_d
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    // a set in the same cycle as a clear keeps the flag
    assign flag_d[i] = set_i[i] || (flag_q[i] && !clr_i[i]);

    always_ff @(posedge clk) begin
      if (rst) flag_q[i] <= 1'b0;
      else     flag_q[i] <= flag_d[i];
    end
  end
endmodule

// File: rtl/crypto_status_unit.sv
module crypto_status_unit
  import cst_pkg::*;
#(
  parameter int WORDS       = 4,
  parameter int CALC_CYCLES = 10
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        eng_en,
  input  logic        host_wr_din,
  input  logic        host_rd_dout,
  input  logic        key_deriv,
  input  logic        aead_en,
  input  logic        aead_is_gcm,
  input  logic [1:0]  aead_phase,
  input  logic        dir_encrypt,
  input  logic        err_clr,
  input  logic        ccf_clr,
  input  logic        err_ie,
  output logic [31:0] status_word,
  output logic        err_irq
);
  phase_t          phase_q;
  logic            calc_done, busy_d;
  logic            wr_evt, rd_evt, skip_out, busy_gate;
  logic [FL_N-1:0] fl_set, fl_clr, fl_q, fl_d;
  logic            busy_q, irq_q;

  cst_phase_tracker #(
    .WORDS      (WORDS),
    .CALC_CYCLES(CALC_CYCLES)
  ) u_track (
    .clk      (clk),
    .rst      (rst),
    .eng_en   (eng_en),
    .wr_stb   (host_wr_din),
    .rd_stb   (host_rd_dout),
    .skip_out (skip_out),
    .phase_q  (phase_q),
    .calc_done(calc_done),
    .busy_d   (busy_d)
  );

  cst_access_guard u_guard (
    .eng_en     (eng_en),
    .phase      (phase_q),
    .wr_stb     (host_wr_din),
    .rd_stb     (host_rd_dout),
    .key_deriv  (key_deriv),
    .aead_en    (aead_en),
    .aead_is_gcm(aead_is_gcm),
    .aead_phase (aead_phase),
    .dir_encrypt(dir_encrypt),
    .wr_evt     (wr_evt),
    .rd_evt     (rd_evt),
    .skip_out   (skip_out),
    .busy_gate  (busy_gate)
  );

  always_comb begin
    fl_set         = '0;
    fl_clr         = '0;
    fl_set[FL_CCF] = calc_done;
    fl_set[FL_RD]  = rd_evt;
    fl_set[FL_WR]  = wr_evt;
    fl_clr[FL_CCF] = ccf_clr;
    fl_clr[FL_RD]  = err_clr;
    fl_clr[FL_WR]  = err_clr;
  end

  cst_flag_bank #(.N(FL_N)) u_flags (
    .clk   (clk),
    .rst   (rst),
    .set_i (fl_set),
    .clr_i (fl_clr),
    .flag_q(fl_q),
    .flag_d(fl_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      busy_q <= busy_gate && busy_d;
      irq_q  <= (fl_d[FL_RD] || fl_d[FL_WR]) && err_ie;
    end
  end

  always_comb begin
    status_word          = '0;
    status_word[FL_N-1:0] = fl_q;
    status_word[ST_BUSY] = busy_q;
  end

  assign err_irq = irq_q;
endmodule

// File: rtl/cst_status_checker.sv
module cst_status_checker (
  input logic        clk,
  input logic        rst,
  input logic [31:0] status_word,
  input logic        err_irq,
  input logic        err_clr,
  input logic        ccf_clr,
  input logic        err_ie,
  input logic        key_deriv,
  input logic        aead_en,
  input logic        aead_is_gcm,
  input logic [1:0]  aead_phase,
  input logic        dir_encrypt,
  input logic        wr_evt,
  input logic        rd_evt,
  input logic        calc_done
);
  p_reserved_zero_r2: assert property (@(posedge clk) disable iff (rst)
    status_word[31:4] == 28'd0);

  p_wr_sets_r4: assert property (@(posedge clk) disable iff (rst)
    wr_evt |=> status_word[2]);

  p_rd_sets_r5: assert property (@(posedge clk) disable iff (rst)
    rd_evt |=> status_word[1]);

  p_wr_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    (status_word[2] && !err_clr) |=> status_word[2]);

  p_err_cleared_r6: assert property (@(posedge clk) disable iff (rst)
    (err_clr && !wr_evt && !rd_evt) |=> (!status_word[2] && !status_word[1]));

  p_ccf_sets_r3: assert property (@(posedge clk) disable iff (rst)
    calc_done |=> status_word[0]);

  p_ccf_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (status_word[0] && !ccf_clr) |=> status_word[0]);

  p_kd_masked_r9: assert property (@(posedge clk) disable iff (rst)
    key_deriv |-> (!wr_evt && !rd_evt));

  p_busy_gated_r11: assert property (@(posedge clk) disable iff (rst)
    (!aead_en || !aead_is_gcm || (aead_phase != 2'd2) || !dir_encrypt || key_deriv)
      |=> !status_word[3]);

  p_irq_level_r12: assert property (@(posedge clk) disable iff (rst)
    (err_ie && (wr_evt || rd_evt)) |=> err_irq);

  p_irq_off_r12: assert property (@(posedge clk) disable iff (rst)
    !err_ie |=> !err_irq);
endmodule

bind crypto_status_unit cst_status_checker u_chk (
  .clk        (clk),
  .rst        (rst),
  .status_word(status_word),
  .err_irq    (err_irq),
  .err_clr    (err_clr),
  .ccf_clr    (ccf_clr),
  .err_ie     (err_ie),
  .key_deriv  (key_deriv),
  .aead_en    (aead_en),
  .aead_is_gcm(aead_is_gcm),
  .aead_phase (aead_phase),
  .dir_encrypt(dir_encrypt),
  .wr_evt     (wr_evt),
  .rd_evt     (rd_evt),
  .calc_done  (calc_done)
);

// File: tb/sim_crypto_status_unit.sv
`timescale 1ns/1ps
module sim_crypto_status_unit;
  localparam int L        = 10;
  localparam int WD_LIMIT = 20000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        eng_en = 1'b1, host_wr_din = 1'b0, host_rd_dout = 1'b0;
  logic        key_deriv = 1'b0, aead_en = 1'b0, aead_is_gcm = 1'b0;
  logic [1:0]  aead_phase = 2'd0;
  logic        dir_encrypt = 1'b0, err_clr = 1'b0, ccf_clr = 1'b0, err_ie = 1'b0;
  logic [31:0] status_word;
  logic        err_irq;

  int n_checks = 0, n_fail = 0, cyc = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  crypto_status_unit #(.WORDS(4), .CALC_CYCLES(L)) u0 (
    .clk(clk), .rst(rst), .eng_en(eng_en), .host_wr_din(host_wr_din),
    .host_rd_dout(host_rd_dout), .key_deriv(key_deriv), .aead_en(aead_en),
    .aead_is_gcm(aead_is_gcm), .aead_phase(aead_phase), .dir_encrypt(dir_encrypt),
    .err_clr(err_clr), .ccf_clr(ccf_clr), .err_ie(err_ie),
    .status_word(status_word), .err_irq(err_irq)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %08h expected %08h", req, what, act, exp);
    end
  endtask

  task automatic st(input string req, input string what, input logic [31:0] exp);
    chk(req, what, status_word, exp);
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_wr();
    host_wr_din = 1'b1; tick(); host_wr_din = 1'b0;
  endtask

  task automatic do_rd();
    host_rd_dout = 1'b1; tick(); host_rd_dout = 1'b0;
  endtask

  task automatic fill(input int n = 4);
    for (int i = 0; i < n; i++) do_wr();
  endtask

  task automatic drain();
    for (int i = 0; i < 4; i++) do_rd();
  endtask

  task automatic clr_all();
    err_clr = 1'b1; ccf_clr = 1'b1; tick(); err_clr = 1'b0; ccf_clr = 1'b0;
  endtask

  task automatic t_reset();
    st("R1", "status after reset", 32'h0);
    chk("R1", "irq after reset", {31'd0, err_irq}, 32'h0);
  endtask

  task automatic t_block();
    fill();
    st("R5", "no error on legal writes", 32'h0);
    tick(L - 1);
    st("R3", "ccf one edge early", 32'h0);
    tick();
    st("R3", "ccf at latency", 32'h1);
    drain();
    st("R5", "legal reads no error", 32'h1);
    do_rd();
    st("R3", "back in input after four reads", 32'h3);
    clr_all();
    st("R6", "clear all", 32'h0);
  endtask

  task automatic t_illegal();
    fill(); tick(); do_wr();
    st("R4", "write in compute", 32'h4);
    tick(L - 3);
    st("R8", "ccf not early after illegal write", 32'h4);
    tick();
    st("R8", "ccf on time after illegal write", 32'h5);
    chk("R12", "irq masked by enable", {31'd0, err_irq}, 32'h0);
    err_clr = 1'b1; tick(); err_clr = 1'b0;
    st("R7", "err_clr keeps ccf", 32'h1);
    do_wr();
    st("R4", "write in output", 32'h5);
    err_clr = 1'b1; tick(); err_clr = 1'b0;
    drain();
    st("R8", "illegal write not counted", 32'h1);
    do_rd();
    st("R8", "four reads exactly", 32'h3);
    clr_all();
    fill(); tick(); do_rd();
    st("R5", "read in compute", 32'h2);
    tick(L - 2);
    st("R5", "ccf with read error", 32'h3);
    drain(); clr_all();
    st("R6", "clear after compute read", 32'h0);
  endtask

  task automatic t_irq();
    do_rd();
    st("R5", "read in input", 32'h2);
    chk("R12", "irq disabled", {31'd0, err_irq}, 32'h0);
    err_ie = 1'b1; tick();
    chk("R12", "irq after enable", {31'd0, err_irq}, 32'h1);
    err_ie = 1'b0; tick();
    chk("R12", "irq after disable", {31'd0, err_irq}, 32'h0);
    err_ie = 1'b1; tick();
    err_clr = 1'b1; tick(); err_clr = 1'b0;
    st("R6", "flags cleared", 32'h0);
    chk("R12", "irq follows clear", {31'd0, err_irq}, 32'h0);
    err_ie = 1'b0;
  endtask

  task automatic t_collide();
    do_rd();
    host_rd_dout = 1'b1; err_clr = 1'b1; tick();
    host_rd_dout = 1'b0; err_clr = 1'b0;
    st("R6", "set wins over clear", 32'h2);
    err_clr = 1'b1; tick(); err_clr = 1'b0;
    st("R6", "lone clear", 32'h0);
    fill(); tick(L - 1);
    ccf_clr = 1'b1; tick(); ccf_clr = 1'b0;
    st("R7", "completion wins over clear", 32'h1);
    ccf_clr = 1'b1; tick(); ccf_clr = 1'b0;
    st("R7", "lone ccf clear", 32'h0);
    drain(); do_rd();
    ccf_clr = 1'b1; tick(); ccf_clr = 1'b0;
    st("R6", "ccf_clr keeps error", 32'h2);
    clr_all();
  endtask

  task automatic t_keyderiv();
    key_deriv = 1'b1;
    do_rd();
    st("R9", "read masked", 32'h0);
    fill(); tick(); do_wr();
    st("R9", "write masked", 32'h0);
    tick(L - 2);
    st("R9", "ccf in key derivation", 32'h1);
    key_deriv = 1'b0;
    do_wr();
    st("R9", "output skipped", 32'h1);
    do_rd();
    st("R9", "detection restored", 32'h3);
    clr_all();
    fill(3); tick(L); drain(); clr_all();
  endtask

  task automatic t_aead();
    aead_en = 1'b1; aead_is_gcm = 1'b0; aead_phase = 2'd0;
    do_rd();
    st("R10", "init read masked", 32'h0);
    fill(); tick(); do_wr(); do_rd();
    st("R10", "init compute masked", 32'h0);
    tick(L - 3);
    st("R10", "init ccf", 32'h1);
    aead_phase = 2'd2;
    do_rd();
    st("R10", "init skipped output", 32'h3);
    clr_all();
    aead_phase = 2'd1;
    do_rd();
    st("R10", "header read masked", 32'h0);
    fill(); tick(); do_wr();
    st("R10", "header write detected", 32'h4);
    tick(L - 2);
    st("R10", "header ccf", 32'h5);
    err_clr = 1'b1; tick(); err_clr = 1'b0;
    aead_phase = 2'd2;
    do_wr();
    st("R10", "header skipped output", 32'h1);
    clr_all(); fill(3); tick(L);
    st("R11", "no busy in CCM payload", 32'h1);
    drain(); clr_all();
    aead_en = 1'b0; aead_phase = 2'd0;
  endtask

  task automatic t_busy();
    aead_en = 1'b1; aead_is_gcm = 1'b1; aead_phase = 2'd2; dir_encrypt = 1'b1;
    tick();
    st("R11", "idle at boundary", 32'h0);
    do_wr();
    st("R11", "busy mid block", 32'h8);
    fill(3); tick(L - 1);
    st("R11", "busy in compute", 32'h8);
    tick();
    st("R11", "busy in output", 32'h9);
    drain();
    st("R11", "idle after block", 32'h1);
    clr_all();
    dir_encrypt = 1'b0;
    do_wr();
    st("R11", "no busy when decrypting", 32'h0);
    dir_encrypt = 1'b1; tick();
    st("R11", "busy returns", 32'h8);
    aead_phase = 2'd3; tick();
    st("R11", "no busy in final", 32'h0);
    aead_phase = 2'd2;
    fill(3); tick(L); drain(); clr_all();
    aead_en = 1'b0; aead_is_gcm = 1'b0; aead_phase = 2'd0; dir_encrypt = 1'b0;
  endtask

  task automatic t_disable();
    fill(2);
    eng_en = 1'b0;
    do_wr(); do_rd();
    st("R13", "no errors while disabled", 32'h0);
    eng_en = 1'b1;
    fill(2); tick(L);
    st("R13", "word count restarted", 32'h0);
    fill(2); tick(L);
    st("R13", "block after re-enable", 32'h1);
    drain(); clr_all();
    st("R2", "final status", 32'h0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc >= WD_LIMIT && !done) begin
      n_checks++; n_fail++;
      $display("FAIL R3 watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst = 1'b0;
    tick();
    t_reset();
    t_block();
    t_illegal();
    t_irq();
    t_collide();
    t_keyderiv();
    t_aead();
    t_busy();
    t_disable();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule